// File: doc/BRIEF.md
# Triple Reloadable Timer Peripheral

The block holds three independent 32-bit timers behind an 8-bit register bus that spans a 64-byte address window. Each timer owns a counter, a reload value and two compare values. It steps once per core clock, or once per pulse of a slow tick-enable input when its slow source is selected, and counts either up or down. A timer that steps while its counter is zero takes the reload value instead of moving by one.

Two registers are shared by all three timers. A control word packs, for each timer, an enable, a clock source bit, an overflow event enable and a direction bit. An event word collects two compare hits and one reload event per timer; software clears its bits by writing ones. The single interrupt output is high whenever any event bit is set. A 12-bit mask word can be read and written but does not gate the interrupt. A fixed revision word completes the map. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `tri_timer`

## Requirements
- R1: Timer n (n = 0, 1, 2) occupies offsets 0x10·n to 0x10·n+0xF, with the counter at +0x0, the reload at +0x4, compare 1 at +0x8 and compare 2 at +0xC. Each register is little-endian, with byte k at offset +k. A byte write changes only that byte.
- R2: With the control bits enable=1, source=0 and direction=0, the counter falls by one on every core clock edge.
- R3: With direction=1, the counter rises by one on every step and wraps from 0xFFFFFFFF to 0.
- R4: With source=1, an enabled timer steps only on edges where `slow_tick` is high.
- R5: A step taken while the counter is 0 loads the reload value, in either direction.
- R6: The reload event sets the timer's overflow event bit only when its overflow enable bit is set. Control word at 0x30: the enable is bit 3n, the source is bit 3n+1, the overflow enable is bit 3n+2, and the direction is bit 9+n.
- R7: When a step produces a value equal to compare 1 or compare 2, event bit 3n or 3n+1 is set at that edge. The event word is at 0x34 and overflow is bit 3n+2.
- R8: Writing a 1 to an event bit clears it, and writing a 0 leaves it unchanged. An event that occurs at the same edge as the clearing write leaves the bit set.
- R9: `irq` is high exactly when any event bit is set. The mask word at 0x38 (12 bits) reads back what was written and has no effect on `irq`.
- R10: Offsets 0x3C to 0x3F read 0x01, 0x08, 0x01, 0x00 and ignore writes. Control bits above 11, event bits above 8 and mask bits above 11 read as zero.
- R11: A disabled timer holds its count. A counter byte write at an edge where the timer would step takes the written byte, and no step occurs at that edge.
- R12: After reset, every register except the revision word reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle 32768 Hz step enable, synchronous to clk |
| bus_addr | input | 6 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one byte per edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for bus_addr, combinational |
| irq | output | 1 | OR of all event bits |

## Verification
The assertions assume that `slow_tick` is already synchronous to the core clock and that each pulse lasts one cycle. They also assume that the bus makes at most one byte write per edge and that `bus_addr` is stable around the edge. The bench drives every input on the falling edge, makes each tick pulse exactly one cycle wide, and reads counters only after the timer has been stopped, so a multi-byte read never sees a moving value. Cycle-exact step counts are derived from the edge at which the enabling and disabling control writes land.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;
  localparam int LANES  = REG_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [REG_W-1:0] REV_WORD = 32'h0001_0801;

  typedef logic [REG_W-1:0] word_t;

  typedef struct packed {
    logic up;
    logic ovf_ie;
    logic slow;
    logic en;
  } tmr_cfg_t;

  function automatic word_t put_byte(word_t old, logic [LANE_W-1:0] lane,
                                     logic [7:0] d);
    word_t r;
    r = old;
    for (int b = 0; b < LANES; b++)
      if (lane == LANE_W'(b)) r[8*b +: 8] = d;
    return r;
  endfunction
endpackage

// File: rtl/tt_timer.sv
module tt_timer
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_reg,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_data,
  input  tmr_cfg_t          cfg,
  input  logic              slow_tick,
  output word_t             cnt_o,
  output word_t             rld_o,
  output word_t             cmp1_o,
  output word_t             cmp2_o,
  output logic              step_o,
  output logic              zero_o,
  output logic              hit1_o,
  output logic              hit2_o
);
  word_t regs_q [4];
  word_t cnt_nxt;
  logic  cnt_wr;
  logic  step;
  logic  at_zero;

  assign cnt_wr  = wr_en && (wr_reg == 2'd0);
  assign step    = cfg.en && (!cfg.slow || slow_tick) && !cnt_wr;
  assign at_zero = (regs_q[0] == '0);

  always_comb begin
    if (at_zero)     cnt_nxt = regs_q[1];
    else if (cfg.up) cnt_nxt = regs_q[0] + 1'b1;
    else             cnt_nxt = regs_q[0] - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) regs_q[k] <= '0;
    end else begin
      for (int k = 1; k < 4; k++)
        if (wr_en && wr_reg == 2'(k))
          regs_q[k] <= put_byte(regs_q[k], wr_lane, wr_data);
      if (cnt_wr)    regs_q[0] <= put_byte(regs_q[0], wr_lane, wr_data);
      else if (step) regs_q[0] <= cnt_nxt;
    end
  end

  assign cnt_o  = regs_q[0];
  assign rld_o  = regs_q[1];
  assign cmp1_o = regs_q[2];
  assign cmp2_o = regs_q[3];
  assign step_o = step;
  assign zero_o = step && at_zero;
  assign hit1_o = step && (cnt_nxt == regs_q[2]);
  assign hit2_o = step && (cnt_nxt == regs_q[3]);
endmodule

// File: rtl/tt_shared.sv
module tt_shared
  import tt_pkg::*;
#(
  parameter int NTMR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_reg,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_data,
  input  logic [NTMR-1:0]   zero_i,
  input  logic [NTMR-1:0]   hit1_i,
  input  logic [NTMR-1:0]   hit2_i,
  output tmr_cfg_t          cfg_o [NTMR],
  output logic [4*NTMR-1:0] ctrl_o,
  output logic [3*NTMR-1:0] sts_o,
  output logic [3*NTMR-1:0] sts_set_o,
  output logic [4*NTMR-1:0] mask_o
);
  localparam int CTL_W = 4 * NTMR;
  localparam int STS_W = 3 * NTMR;

  logic [CTL_W-1:0] ctrl_q, mask_q;
  logic [STS_W-1:0] sts_q, sts_set, sts_clr;

  for (genvar i = 0; i < NTMR; i++) begin : g_map
    assign cfg_o[i].en     = ctrl_q[3*i];
    assign cfg_o[i].slow   = ctrl_q[3*i+1];
    assign cfg_o[i].ovf_ie = ctrl_q[3*i+2];
    assign cfg_o[i].up     = ctrl_q[3*NTMR+i];
    assign sts_set[3*i]    = hit1_i[i];
    assign sts_set[3*i+1]  = hit2_i[i];
    assign sts_set[3*i+2]  = zero_i[i] && ctrl_q[3*i+2];
  end

  assign sts_clr = (wr_en && wr_reg == 2'd1)
                 ? STS_W'(put_byte('0, wr_lane, wr_data)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      sts_q  <= '0;
    end else begin
      if (wr_en && wr_reg == 2'd0)
        ctrl_q <= CTL_W'(put_byte(REG_W'(ctrl_q), wr_lane, wr_data));
      if (wr_en && wr_reg == 2'd2)
        mask_q <= CTL_W'(put_byte(REG_W'(mask_q), wr_lane, wr_data));
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign sts_o     = sts_q;
  assign sts_set_o = sts_set;
  assign mask_o    = mask_q;
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tt_pkg::*;
#(
  parameter int NTMR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int CTL_W = 4 * NTMR;
  localparam int STS_W = 3 * NTMR;
  localparam logic [1:0] SHARED_BLK = 2'd3;

  logic [1:0]        blk, wreg;
  logic [LANE_W-1:0] lane;
  assign blk  = bus_addr[5:4];
  assign wreg = bus_addr[3:2];
  assign lane = bus_addr[LANE_W-1:0];

  tmr_cfg_t          cfg [NTMR];
  logic [NTMR-1:0]   step_w, zero_w, hit1_w, hit2_w;
  word_t             cnt_w [NTMR];
  word_t             rld_w [NTMR];
  word_t             cmp1_w [NTMR];
  word_t             cmp2_w [NTMR];
  logic [CTL_W-1:0]  ctrl_w, mask_w;
  logic [STS_W-1:0]  sts_w, sts_set_w;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    tt_timer u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && blk == 2'(i)),
      .wr_reg   (wreg),
      .wr_lane  (lane),
      .wr_data  (bus_wdata),
      .cfg      (cfg[i]),
      .slow_tick(slow_tick),
      .cnt_o    (cnt_w[i]),
      .rld_o    (rld_w[i]),
      .cmp1_o   (cmp1_w[i]),
      .cmp2_o   (cmp2_w[i]),
      .step_o   (step_w[i]),
      .zero_o   (zero_w[i]),
      .hit1_o   (hit1_w[i]),
      .hit2_o   (hit2_w[i])
    );
  end

  tt_shared #(.NTMR(NTMR)) u_shared (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && blk == SHARED_BLK),
    .wr_reg   (wreg),
    .wr_lane  (lane),
    .wr_data  (bus_wdata),
    .zero_i   (zero_w),
    .hit1_i   (hit1_w),
    .hit2_i   (hit2_w),
    .cfg_o    (cfg),
    .ctrl_o   (ctrl_w),
    .sts_o    (sts_w),
    .sts_set_o(sts_set_w),
    .mask_o   (mask_w)
  );

  word_t rd_word;
  always_comb begin
    rd_word = '0;
    if (blk == SHARED_BLK) begin
      case (wreg)
        2'd0:    rd_word = REG_W'(ctrl_w);
        2'd1:    rd_word = REG_W'(sts_w);
        2'd2:    rd_word = REG_W'(mask_w);
        default: rd_word = REV_WORD;
      endcase
    end else begin
      for (int i = 0; i < NTMR; i++) begin
        if (blk == 2'(i)) begin
          case (wreg)
            2'd0:    rd_word = cnt_w[i];
            2'd1:    rd_word = rld_w[i];
            2'd2:    rd_word = cmp1_w[i];
            default: rd_word = cmp2_w[i];
          endcase
        end
      end
    end
  end

  assign bus_rdata = rd_word[8*lane +: 8];
  assign irq       = |sts_w;
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
#(
  parameter int NTMR = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [4*NTMR-1:0] ctrl_w,
  input logic [3*NTMR-1:0] sts_w,
  input logic [3*NTMR-1:0] sts_set_w,
  input logic [NTMR-1:0]   step_w,
  input word_t             cnt_w [NTMR],
  input word_t             rld_w [NTMR]
);
  localparam int STS_W = 3 * NTMR;

  for (genvar i = 0; i < NTMR; i++) begin : g_tc
    // R5: a step from zero lands on the reload value
    assert_reload_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_w[i] && cnt_w[i] == '0) |=> (cnt_w[i] == $past(rld_w[i])));

    // R11: no enable and no counter write means no change
    assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_w[3*i] && !(bus_wr && bus_addr[5:4] == 2'(i) && bus_addr[3:2] == 2'd0))
      |=> $stable(cnt_w[i]));

    // R4: slow source only moves on a tick
    assert_slow_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_w[3*i+1] && !slow_tick) |-> !step_w[i]);

    // R6: overflow event only with its enable set
    assert_ovf_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_w[3*i+2]) |-> $past(ctrl_w[3*i+2]));
  end

  for (genvar k = 0; k < STS_W; k++) begin : g_sc
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(6'h34 + k / 8);
    // R8: a written one clears the bit unless an event sets it again
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SADDR && bus_wdata[k%8] && !sts_set_w[k])
      |=> !sts_w[k]);
  end

  // R10: revision low byte is fixed
  assert_rev_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h3C) |-> (bus_rdata == 8'h01));
endmodule

bind tri_timer tt_checker #(.NTMR(NTMR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_tick(slow_tick),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ctrl_w   (ctrl_w),
  .sts_w    (sts_w),
  .sts_set_w(sts_set_w),
  .step_w   (step_w),
  .cnt_w    (cnt_w),
  .rld_w    (rld_w)
);

// File: tb/sim_tri_timer.sv
module sim_tri_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_timer u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr8(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) wr8(a + 6'(b), d[8*b +: 8]);
  endtask

  task automatic rd8(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] d);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin
      rd8(a + 6'(b), t);
      d[8*b +: 8] = t;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_tick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd32(6'h30, v); chk("R12 ctrl", v, 0);
    rd32(6'h34, v); chk("R12 status", v, 0);
    rd32(6'h00, v); chk("R12 counter", v, 0);
    chk("R12 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v; logic [7:0] b;
    wr32(6'h14, 32'h1122_3344);
    rd8(6'h14, b); chk("R1 byte0", {24'd0, b}, 32'h44);
    rd8(6'h17, b); chk("R1 byte3", {24'd0, b}, 32'h11);
    wr8(6'h16, 8'hAB);
    rd32(6'h14, v); chk("R1 single byte", v, 32'h11AB_3344);
    wr32(6'h28, 32'hCAFE_0001);
    rd32(6'h28, v); chk("R1 timer3 cmp1", v, 32'hCAFE_0001);
  endtask

  task automatic t_rev();
    logic [31:0] v; logic [7:0] b;
    wr8(6'h3C, 8'hFF);
    rd32(6'h3C, v); chk("R10 revision", v, 32'h0001_0801);
    wr8(6'h31, 8'hFF);
    rd8(6'h31, b); chk("R10 ctrl upper zero", {24'd0, b}, 32'h0F);
    rd8(6'h32, b); chk("R10 ctrl byte2 zero", {24'd0, b}, 0);
    wr8(6'h31, 8'h00);
  endtask

  task automatic t_down();
    logic [31:0] v;
    wr32(6'h08, 32'hDEAD_0000);
    wr32(6'h0C, 32'hDEAD_0001);
    wr32(6'h00, 32'd100);
    wr8(6'h30, 8'h01);
    idle(6);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R2 count down", v, 32'd93);
  endtask

  task automatic t_up();
    logic [31:0] v;
    wr32(6'h00, 32'hFFFF_FFFE);
    wr32(6'h04, 32'h20);
    wr8(6'h31, 8'h02);
    wr8(6'h30, 8'h01);
    idle(1);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R3 wrap to zero", v, 0);
    wr8(6'h30, 8'h01);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R5 reload counting up", v, 32'h20);
    rd32(6'h34, v); chk("R6 no overflow bit without enable", v, 0);
    wr8(6'h31, 8'h00);
  endtask

  task automatic t_slow();
    logic [31:0] v;
    wr32(6'h00, 32'd1000);
    wr8(6'h30, 8'h03);
    idle(4);
    pulse_tick(); idle(2);
    pulse_tick(); idle(2);
    pulse_tick(); idle(1);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R4 slow steps", v, 32'd997);
  endtask

  task automatic t_ovf();
    logic [31:0] v; logic [7:0] b;
    wr32(6'h00, 32'd2);
    wr32(6'h04, 32'd5);
    wr8(6'h30, 8'h05);
    idle(3);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R5 reload counting down", v, 32'd4);
    rd8(6'h34, b); chk("R6 overflow bit", {24'd0, b}, 32'h04);
    chk("R9 irq on event", {31'd0, irq}, 1);
    wr8(6'h38, 8'hFF); wr8(6'h39, 8'hFF);
    rd8(6'h39, b); chk("R9 mask readback", {24'd0, b}, 32'h0F);
    chk("R9 mask no effect set", {31'd0, irq}, 1);
    wr8(6'h34, 8'h04);
    rd8(6'h34, b); chk("R8 clear overflow", {24'd0, b}, 0);
    chk("R9 irq low", {31'd0, irq}, 0);
    wr8(6'h38, 8'h00); wr8(6'h39, 8'h00);
  endtask

  task automatic t_match();
    logic [31:0] v; logic [7:0] b;
    wr32(6'h10, 32'd10);
    wr32(6'h18, 32'd7);
    wr32(6'h1C, 32'd3);
    wr8(6'h30, 8'h08);
    idle(4);
    wr8(6'h30, 8'h00);
    rd32(6'h10, v); chk("R2 timer2 count", v, 32'd5);
    rd8(6'h34, b); chk("R7 cmp1 hit only", {24'd0, b}, 32'h08);
    wr8(6'h34, 8'h00);
    rd8(6'h34, b); chk("R8 zero write keeps", {24'd0, b}, 32'h08);
    wr8(6'h34, 8'h08);
    rd8(6'h34, b); chk("R8 one write clears", {24'd0, b}, 0);
    wr32(6'h10, 32'd5);
    wr8(6'h30, 8'h08);
    idle(1);
    wr8(6'h30, 8'h00);
    rd8(6'h34, b); chk("R7 cmp2 hit", {24'd0, b}, 32'h10);
    wr8(6'h34, 8'h10);
  endtask

  task automatic t_setwins();
    logic [31:0] v; logic [7:0] b;
    wr32(6'h20, 32'd50);
    wr32(6'h28, 32'd49);
    wr8(6'h30, 8'h40);
    wr8(6'h34, 8'h40);
    wr8(6'h30, 8'h00);
    rd32(6'h20, v); chk("R2 timer3 count", v, 32'd48);
    rd8(6'h34, b); chk("R8 set wins over clear", {24'd0, b}, 32'h40);
    wr8(6'h34, 8'h40);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr32(6'h00, 32'h100);
    wr8(6'h30, 8'h01);
    wr8(6'h00, 8'h80);
    wr8(6'h30, 8'h00);
    rd32(6'h00, v); chk("R11 write beats step", v, 32'h17F);
    idle(5);
    rd32(6'h00, v); chk("R11 disabled hold", v, 32'h17F);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rev();
    t_down();
    t_up();
    t_slow();
    t_ovf();
    t_match();
    t_setwins();
    t_prio();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule